// File: doc/BRIEF.md
# Auxiliary Channel Ownership Arbiter

This block decides who may drive one display auxiliary channel: a host software port or an embedded microcontroller port. It holds a 2-bit ownership status. The microcontroller takes an idle channel with a single-cycle take pulse and hands it back with a single-cycle give-back pulse. The host asks with a single-cycle request pulse. It is refused at once, with no queuing, if the microcontroller already owns the channel.

When the host asks and the channel has never been enabled, the block first brings the channel up. It raises the enable and the channel reset together. It then polls the reset-done input at a fixed cadence until the input reads 1. After that it drops the reset and polls until reset-done reads 0. Each wait has a bounded number of polls. Only then does it try to claim the channel for the host.

The claim succeeds only if the status can move to host-owned in that cycle. A grant pulse is issued in the same cycle as that status change; otherwise a refuse pulse is issued. If either reset wait runs out of polls, the block abandons the attempt. It pulses an error, drops the enable and the reset, and leaves the status untouched. The host gives the channel back with a release pulse.

Top module: `aux_own_arb`

## Requirements
- R1: The status `own_st` encodes 0 = idle, 1 = host owns, 2 = microcontroller owns; 3 never occurs. After reset: `own_st` = 0, `chan_en` = 0, `chan_rst` = 0, and `host_grant`, `host_refuse`, `host_err` are 0.
- R2: A `mcu_take` pulse while the status is idle sets the status to 2 on the next cycle. A `mcu_take` pulse while the host owns the channel is ignored and the status stays 1. A `mcu_give` pulse while the status is 2 returns it to 0.
- R3: A `host_req` pulse while the status is 2 gives a one-cycle `host_refuse` on the cycle after the pulse. In that case `chan_rst` is not raised, no grant is given, and the status stays 2.
- R4: A `host_req` pulse, not refused, while `chan_en` is 0 sets both `chan_en` and `chan_rst` to 1 on the cycle after the pulse.
- R5: While `chan_rst` is high, `rst_done` is sampled once every POLL_CYC cycles, for at most POLL_MAX samples. The first sample that reads 1 drops `chan_rst`, so `chan_rst` stays high for a whole multiple of POLL_CYC cycles.
- R6: After `chan_rst` drops, `rst_done` is sampled at the same cadence and with the same limit until a sample reads 0. The host claim then follows, with the grant one cycle after that sample.
- R7: If either wait reaches POLL_MAX samples without the awaited value, `host_err` pulses for one cycle, `chan_rst` and `chan_en` go to 0, no grant is given, and the status is unchanged.
- R8: `host_grant` is a one-cycle pulse that is high in the same cycle the status first reads 1. With `chan_en` already 1, it comes two cycles after the `host_req` pulse.
- R9: A `host_rel` pulse while the host owns the channel returns the status to 0.
- R10: When the host claim and a `mcu_take` pulse meet in the same cycle on an idle channel, the microcontroller wins. The status becomes 2 and the host gets `host_refuse` instead of a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host acquire pulse |
| host_rel | input | 1 | Host done-using pulse |
| mcu_take | input | 1 | Microcontroller take pulse |
| mcu_give | input | 1 | Microcontroller give-back pulse |
| rst_done | input | 1 | Reset-done indication from the channel |
| chan_rst | output | 1 | Channel reset request |
| chan_en | output | 1 | Channel enable |
| own_st | output | 2 | Ownership status: 0 idle, 1 host, 2 microcontroller |
| host_grant | output | 1 | Host claim succeeded (one cycle) |
| host_refuse | output | 1 | Host claim refused (one cycle) |
| host_err | output | 1 | Reset handshake timed out (one cycle) |

## Verification
The host claim and the microcontroller take can land on the status register in the same cycle. The bench provokes this in two ways. In the first, `host_req` and `mcu_take` are pulsed together on an idle, enabled channel. In the second, `mcu_take` is pulsed exactly one cycle after `host_req`, so it arrives in the cycle where the sequencer makes its claim. In both cases the bench expects status 2 and a refuse pulse with no grant; a grant is judged a failure. Randomly interleaved host and microcontroller pulses are then checked against a bench ownership model.

// File: rtl/aux_arb_pkg.sv
package aux_arb_pkg;

  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_MCU  = 2'd2
  } own_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_RST_HI = 2'd1,
    SQ_RST_LO = 2'd2,
    SQ_CLAIM  = 2'd3
  } seq_e;

  // Host may take the channel: it already owns it, or the channel is idle
  // and the microcontroller is not taking it in the same cycle.
  function automatic logic host_may_take(own_e cur, logic mcu_take);
    return (cur == OWN_HOST) || ((cur == OWN_IDLE) && !mcu_take);
  endfunction

  // Next ownership value; the microcontroller has priority on an idle channel.
  function automatic own_e own_next(own_e cur, logic host_take, logic host_rel,
                                    logic mcu_take, logic mcu_give);
    own_e nxt;
    nxt = cur;
    if (cur == OWN_IDLE && mcu_take)       nxt = OWN_MCU;
    else if (host_take)                    nxt = OWN_HOST;
    else if (cur == OWN_HOST && host_rel)  nxt = OWN_IDLE;
    else if (cur == OWN_MCU && mcu_give)   nxt = OWN_IDLE;
    return nxt;
  endfunction

endpackage

// File: rtl/aux_poll_timer.sv
module aux_poll_timer #(
  parameter int POLL_CYC = 125,
  parameter int POLL_MAX = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic sample,
  output logic last
);
  localparam int TW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [TW-1:0] TICK_END = TW'(POLL_CYC - 1);
  localparam logic [PW-1:0] POLL_END = PW'(POLL_MAX - 1);

  logic [TW-1:0] tick_q;
  logic [PW-1:0] poll_q;

  assign sample = run && (tick_q == TICK_END);
  assign last   = sample && (poll_q == POLL_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      poll_q <= '0;
    end else if (!run || restart) begin
      tick_q <= '0;
      poll_q <= '0;
    end else if (sample) begin
      tick_q <= '0;
      poll_q <= poll_q + 1'b1;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assert_poll_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q <= PW'(POLL_MAX));

  assert_tick_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q <= TICK_END);

endmodule

// File: rtl/aux_own_reg.sv
module aux_own_reg
  import aux_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic claim,
  input  logic host_rel,
  input  logic mcu_take,
  input  logic mcu_give,
  output logic can_take,
  output own_e own_q
);
  logic host_take;

  assign can_take  = host_may_take(own_q, mcu_take);
  assign host_take = claim && can_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_IDLE;
    else        own_q <= own_next(own_q, host_take, host_rel, mcu_take, mcu_give);
  end

  assert_enc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    own_q != own_e'(2'd3));

  assert_mcu_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_IDLE && mcu_take) |=> own_q == OWN_MCU);

  assert_mcu_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_MCU && !mcu_give) |=> own_q == OWN_MCU);

  assert_host_rel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_HOST && host_rel && !claim) |=> own_q == OWN_IDLE);

  assert_mcu_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && own_q == OWN_IDLE && mcu_take) |=> own_q == OWN_MCU);

endmodule

// File: rtl/aux_acq_seq.sv
module aux_acq_seq
  import aux_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  input  logic rst_done,
  input  own_e own_q,
  input  logic can_take,
  input  logic sample,
  input  logic last,
  output logic run,
  output logic restart,
  output logic claim,
  output logic chan_rst,
  output logic chan_en,
  output logic host_grant,
  output logic host_refuse,
  output logic host_err
);
  seq_e st_q;
  logic hi_seen, lo_seen, timed_out;

  assign run       = (st_q == SQ_RST_HI) || (st_q == SQ_RST_LO);
  assign hi_seen   = (st_q == SQ_RST_HI) && sample && rst_done;
  assign lo_seen   = (st_q == SQ_RST_LO) && sample && !rst_done;
  assign timed_out = run && last && !hi_seen && !lo_seen;
  assign restart   = hi_seen;
  assign claim     = (st_q == SQ_CLAIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SQ_IDLE;
      chan_rst    <= 1'b0;
      chan_en     <= 1'b0;
      host_grant  <= 1'b0;
      host_refuse <= 1'b0;
      host_err    <= 1'b0;
    end else begin
      host_grant  <= 1'b0;
      host_refuse <= 1'b0;
      host_err    <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          if (host_req) begin
            if (own_q == OWN_MCU) begin
              host_refuse <= 1'b1;
            end else if (!chan_en) begin
              chan_en  <= 1'b1;
              chan_rst <= 1'b1;
              st_q     <= SQ_RST_HI;
            end else begin
              st_q <= SQ_CLAIM;
            end
          end
        end
        SQ_RST_HI: begin
          if (hi_seen) begin
            chan_rst <= 1'b0;
            st_q     <= SQ_RST_LO;
          end
        end
        SQ_RST_LO: begin
          if (lo_seen) st_q <= SQ_CLAIM;
        end
        SQ_CLAIM: begin
          host_grant  <= can_take;
          host_refuse <= !can_take;
          st_q        <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
      if (timed_out) begin
        chan_rst <= 1'b0;
        chan_en  <= 1'b0;
        host_err <= 1'b1;
        st_q     <= SQ_IDLE;
      end
    end
  end

  assert_en_with_rst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_rst) |-> chan_en);

  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> (!chan_rst && !chan_en && !host_grant));

  assert_abort_own_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> $stable(own_q));

  assert_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_refuse |-> !host_grant);

  assert_grant_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_grant |-> (own_q == OWN_HOST));

endmodule

// File: rtl/aux_own_arb.sv
module aux_own_arb
  import aux_arb_pkg::*;
#(
  parameter int POLL_CYC = 125,
  parameter int POLL_MAX = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_req,
  input  logic       host_rel,
  input  logic       mcu_take,
  input  logic       mcu_give,
  input  logic       rst_done,
  output logic       chan_rst,
  output logic       chan_en,
  output logic [1:0] own_st,
  output logic       host_grant,
  output logic       host_refuse,
  output logic       host_err
);
  own_e own_q;
  logic can_take, claim, run, restart, sample, last;

  aux_poll_timer #(.POLL_CYC(POLL_CYC), .POLL_MAX(POLL_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .sample(sample), .last(last)
  );

  aux_own_reg u_own (
    .clk(clk), .rst_n(rst_n), .claim(claim), .host_rel(host_rel),
    .mcu_take(mcu_take), .mcu_give(mcu_give), .can_take(can_take), .own_q(own_q)
  );

  aux_acq_seq u_seq (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .rst_done(rst_done),
    .own_q(own_q), .can_take(can_take), .sample(sample), .last(last),
    .run(run), .restart(restart), .claim(claim), .chan_rst(chan_rst),
    .chan_en(chan_en), .host_grant(host_grant), .host_refuse(host_refuse),
    .host_err(host_err)
  );

  assign own_st = own_q;

endmodule

// File: tb/aux_own_arb_tb.sv
module aux_own_arb_tb_top;
  localparam int P = 4;
  localparam int M = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 0, host_rel = 0, mcu_take = 0, mcu_give = 0;
  logic rst_done;
  logic chan_rst, chan_en, host_grant, host_refuse, host_err;
  logic [1:0] own_st;

  int checks = 0, errors = 0, cyc = 0;
  int mode = 0, lat = 5;
  logic [31:0] dline = '0;
  int n_grant = 0, n_refuse = 0, n_err = 0, n_rsthi = 0, t_grant = 0;
  logic [1:0] exp_own = 2'd0;

  always #4 clk = ~clk;

  aux_own_arb #(.POLL_CYC(P), .POLL_MAX(M)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_rel(host_rel),
    .mcu_take(mcu_take), .mcu_give(mcu_give), .rst_done(rst_done),
    .chan_rst(chan_rst), .chan_en(chan_en), .own_st(own_st),
    .host_grant(host_grant), .host_refuse(host_refuse), .host_err(host_err)
  );

  always_ff @(posedge clk) dline <= {dline[30:0], chan_rst};
  always_comb rst_done = (mode == 1) ? 1'b0 : (mode == 2) ? 1'b1 : dline[lat-1];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (host_grant) begin n_grant <= n_grant + 1; t_grant <= cyc; end
    if (host_refuse) n_refuse <= n_refuse + 1;
    if (host_err) n_err <= n_err + 1;
    if (chan_rst) n_rsthi <= n_rsthi + 1;
  end

  function automatic int polls_needed(int l, int p);
    return (l + p) / p;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    @(negedge clk);
    n_grant = 0; n_refuse = 0; n_err = 0; n_rsthi = 0;
  endtask

  task automatic pulse(input logic h, input logic ht, input logic mt,
                       input logic mg);
    host_req = h; host_rel = ht; mcu_take = mt; mcu_give = mg;
    @(negedge clk);
    host_req = 0; host_rel = 0; mcu_take = 0; mcu_give = 0;
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 own_st", own_st, 0);
    chk("R1 chan_en", chan_en, 0);
    chk("R1 chan_rst", chan_rst, 0);
    chk("R1 pulses", host_grant | host_refuse | host_err, 0);

    // R7 phase-1 timeout: reset-done never rises
    mode = 1; clr();
    pulse(1, 0, 0, 0);
    chk("R4 en with rst", {chan_en, chan_rst}, 3);
    waitc(M * P + 5);
    chk("R5 polls limit", n_rsthi, M * P);
    chk("R7 err", n_err, 1);
    chk("R7 grant", n_grant, 0);
    chk("R7 en dropped", chan_en, 0);
    chk("R7 own unchanged", own_st, 0);

    // R7 phase-2 timeout: reset-done stuck high
    mode = 2; clr();
    pulse(1, 0, 0, 0);
    waitc(2 * M * P + 5);
    chk("R5 first poll", n_rsthi, P);
    chk("R7 err phase2", n_err, 1);
    chk("R7 rst low", chan_rst, 0);
    chk("R7 en low phase2", chan_en, 0);

    // R5 R6 normal bring-up with latency
    mode = 0; lat = 5; clr();
    k = polls_needed(lat, P);
    pulse(1, 0, 0, 0);
    begin
      int t0;
      t0 = cyc;
      waitc(2 * M * P);
      chk("R5 rst high span", n_rsthi, k * P);
      chk("R6 grant time", t_grant - t0, 2 * k * P + 1);
    end
    chk("R8 grant count", n_grant, 1);
    chk("R8 own host", own_st, 1);
    exp_own = 2'd1;

    // R2 mcu_take while host owns is ignored
    pulse(0, 0, 1, 0); waitc(2);
    chk("R2 ignored", own_st, 1);
    // R9 release
    pulse(0, 1, 0, 0); waitc(2);
    chk("R9 release", own_st, 0);

    // R8 exact timing on enabled channel
    clr();
    pulse(1, 0, 0, 0);
    chk("R8 not yet", host_grant, 0);
    @(negedge clk);
    chk("R8 grant with status", {host_grant, own_st}, 3'b101);
    pulse(0, 1, 0, 0); waitc(2);

    // R2 / R3 refuse while mcu owns
    pulse(0, 0, 1, 0); waitc(1);
    chk("R2 mcu owns", own_st, 2);
    clr();
    pulse(1, 0, 0, 0);
    chk("R3 refuse pulse", host_refuse, 1);
    waitc(4);
    chk("R3 no rst", n_rsthi, 0);
    chk("R3 no grant", n_grant, 0);
    chk("R3 own kept", own_st, 2);
    pulse(0, 0, 0, 1); waitc(1);
    chk("R2 give back", own_st, 0);

    // R10 same-cycle from idle
    clr();
    pulse(1, 0, 1, 0); waitc(4);
    chk("R10 same cycle own", own_st, 2);
    chk("R10 same cycle refuse", n_refuse, 1);
    chk("R10 same cycle grant", n_grant, 0);
    pulse(0, 0, 0, 1); waitc(1);

    // R10 take lands in the claim cycle
    clr();
    pulse(1, 0, 0, 0);
    pulse(0, 0, 1, 0); waitc(4);
    chk("R10 claim cycle own", own_st, 2);
    chk("R10 claim cycle refuse", n_refuse, 1);
    chk("R10 claim cycle grant", n_grant, 0);
    pulse(0, 0, 0, 1); waitc(1);
    exp_own = 2'd0;

    // random interleaving against an ownership model (R2 R3 R8 R9)
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      int op, eg, er;
      op = $urandom_range(3);
      eg = 0; er = 0;
      clr();
      case (op)
        0: begin pulse(0, 0, 1, 0); if (exp_own == 0) exp_own = 2; end
        1: begin pulse(0, 0, 0, 1); if (exp_own == 2) exp_own = 0; end
        2: begin pulse(0, 1, 0, 0); if (exp_own == 1) exp_own = 0; end
        default: begin
          pulse(1, 0, 0, 0);
          if (exp_own == 2) er = 1; else begin eg = 1; exp_own = 1; end
        end
      endcase
      waitc(3);
      chk("R2/R9 random own", own_st, exp_own);
      chk("R8 random grant", n_grant, eg);
      chk("R3 random refuse", n_refuse, er);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule